// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a countdown watchdog that sits on a simple register bus with an address, write data, a write strobe and combinational read data. Software arms it by setting an enable bit together with a 4-bit interval code, and must then keep writing a 12-bit key, together with a restart bit, to a kick register before the interval runs out. A write that carries the wrong key, or that lacks the restart bit, is dropped, so a runaway program that scribbles on the bus cannot keep the timer alive by accident.

The interval is counted in half-second units. A prescaler turns the core clock, whose frequency is the parameter `CLK_HZ`, into a half-second tick. When the count runs out, the configured action is taken. The action is one of three: a system reset pulse `RST_W` cycles wide, a sticky interrupt, or nothing. After that the counter halts until it is reloaded. The bus is not a stream. Every write is taken in the cycle its strobe is high, and there is no back-pressure, so the interface has no valid/ready pair.

Top module: `wdog_keyed`

## Requirements
- R1: After reset every register reads 0 and both `sys_rst_pulse` and `irq` are low.
- R2: A write to the kick register (offset 0x10) restarts the countdown only when the timer is enabled, bit 0 is 1 and bits [12:1] equal 0xA57. Any other kick write has no effect. The kick register always reads 0.
- R3: The interval code is mode bits [7:4]. Code 0 gives 0.5 s. Codes 1 to 6 give 1 to 6 s. Codes 7 to 0xB give 8, 10, 12, 14 and 16 s. Codes 0xC to 0xF give 16 s. Expiry happens exactly interval × `CLK_HZ` clock cycles after the edge that loaded the counter.
- R4: Writing mode (offset 0x18) with bit 0 = 1 while the timer is disabled loads the counter. The same write while it is already enabled leaves the running countdown untouched.
- R5: Any mode write with bit 0 = 0 disables the timer and stops the countdown, so no expiry follows.
- R6: A new interval code written while the timer runs takes effect only at the next valid kick or enable.
- R7: Configuration bits [1:0] (offset 0x14) choose the expiry action. 01 raises `sys_rst_pulse` for exactly `RST_W` cycles. 10 raises the interrupt. 00 and 11 do nothing.
- R8: Configuration bit 4 is the interrupt status. It is set on an expiry while the action is 10, and it drives `irq`. Writing 1 to it clears it. Writing 0 to it leaves it set.
- R9: After an expiry the counter halts, and no further event occurs until a valid kick or a fresh enable.
- R10: Mode bits 0 and [7:4] and configuration bits [1:0] and 4 read back as stored. All other bits, and unmapped offsets, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock at `CLK_HZ` |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst_pulse | output | 1 | System reset request pulse |
| irq | output | 1 | Interrupt, equal to the status bit |

## Verification
The in-line assertions watch four things on every cycle. The counter never grows except on a load coming from a keyed kick or an enable rise. A disabling mode write always leaves the counter disarmed. A reset pulse only starts under the reset action. The interrupt only drops after a write-one-to-clear. The exact length of each of the sixteen intervals, the width of the reset pulse, the halt after expiry, and the rule that a code change waits for the next reload can only be shown by the bench's timed scenarios. The bench measures cycles between the loading edge and the event.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned HALFS_W = 6;

  localparam logic [ADDR_W-1:0] OFS_KICK = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h18;
  localparam logic [11:0]       KICK_KEY = 12'hA57;
  localparam int unsigned       STAT_BIT = 4;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_RESET = 2'b01,
    ACT_IRQ   = 2'b10,
    ACT_IDLE  = 2'b11
  } expiry_act_e;

  // Interval in half-second units for a 4-bit code.
  function automatic logic [HALFS_W-1:0] code_to_halves(input logic [3:0] code);
    logic [3:0] step;
    step = code - 4'd7;
    if (code == 4'd0)       return HALFS_W'(1);
    else if (code <= 4'd6)  return {1'b0, code, 1'b0};
    else if (code <= 4'hB)  return HALFS_W'(16) + {step, 2'b00};
    else                    return HALFS_W'(32);
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned HALF = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] LAST = PW'(HALF - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)                   phase <= '0;
    else if (clr || !run)         phase <= '0;
    else if (phase == LAST)       phase <= '0;
    else                          phase <= phase + 1'b1;
  end

  assign tick = run && (phase == LAST);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              expire,
  output logic [DATA_W-1:0] bus_rdata,
  output expiry_act_e       action,
  output logic [3:0]        load_code,
  output logic              enabled,
  output logic              load,
  output logic              stop,
  output logic              status
);
  logic       wr_kick, wr_cfg, wr_mode, key_ok, en_rise;
  logic [3:0] code_q;

  assign wr_kick = bus_we && (bus_addr == OFS_KICK);
  assign wr_cfg  = bus_we && (bus_addr == OFS_CFG);
  assign wr_mode = bus_we && (bus_addr == OFS_MODE);

  assign key_ok  = wr_kick && bus_wdata[0] && (bus_wdata[12:1] == KICK_KEY);
  assign en_rise = wr_mode && bus_wdata[0] && !enabled;
  assign load    = (key_ok && enabled) || en_rise;
  assign stop    = wr_mode && !bus_wdata[0];
  // An enable rise uses the code written with it; a kick uses the stored one.
  assign load_code = wr_mode ? bus_wdata[7:4] : code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      action  <= ACT_NONE;
      code_q  <= '0;
      enabled <= 1'b0;
      status  <= 1'b0;
    end else begin
      if (wr_cfg)  action <= expiry_act_e'(bus_wdata[1:0]);
      if (wr_mode) begin
        enabled <= bus_wdata[0];
        code_q  <= bus_wdata[7:4];
      end
      // A new event wins over a clear in the same cycle.
      if (expire && (action == ACT_IRQ))       status <= 1'b1;
      else if (wr_cfg && bus_wdata[STAT_BIT])  status <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CFG: begin
        bus_rdata[1:0]      = action;
        bus_rdata[STAT_BIT] = status;
      end
      OFS_MODE: begin
        bus_rdata[0]   = enabled;
        bus_rdata[7:4] = code_q;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               stop,
  input  logic [HALFS_W-1:0] halves,
  input  logic               tick,
  output logic [HALFS_W-1:0] cnt,
  output logic               armed,
  output logic               expire
);
  assign expire = armed && tick && (cnt == HALFS_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (stop) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= halves;
      armed <= 1'b1;
    end else if (expire) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (armed && tick) begin
      cnt   <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200,
  parameter int unsigned RST_W  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  output logic [31:0] bus_rdata,
  output logic        sys_rst_pulse,
  output logic        irq
);
  localparam int unsigned HALF = CLK_HZ / 2;
  localparam int unsigned PCW  = $clog2(RST_W + 1);

  expiry_act_e        action;
  logic [3:0]         load_code;
  logic               enabled, load, stop, status;
  logic               tick, expire, armed;
  logic [HALFS_W-1:0] cnt;
  logic [PCW-1:0]     pulse_left;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .expire(expire), .bus_rdata(bus_rdata), .action(action),
    .load_code(load_code), .enabled(enabled), .load(load), .stop(stop),
    .status(status)
  );

  wdog_prescaler #(.HALF(HALF)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(load), .run(armed), .tick(tick)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .stop(stop),
    .halves(code_to_halves(load_code)), .tick(tick),
    .cnt(cnt), .armed(armed), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                                pulse_left <= '0;
    else if (expire && (action == ACT_RESET))  pulse_left <= PCW'(RST_W);
    else if (pulse_left != '0)                 pulse_left <= pulse_left - 1'b1;
  end

  assign sys_rst_pulse = (pulse_left != '0);
  assign irq           = status;

  // R2: the count only grows on a load from a keyed kick or an enable rise
  a_r2_grow_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > $past(cnt)) |-> $past(load));

  // R5: a disabling mode write always leaves the counter disarmed
  a_r5_stop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_MODE && !bus_wdata[0]) |=> !armed);

  // R7: a reset pulse only starts under the reset action
  a_r7_pulse_needs_action: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_pulse) |-> ($past(action) == ACT_RESET));

  // R8: the interrupt only drops after a write of 1 to the status bit
  a_r8_irq_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_we && bus_addr == OFS_CFG && bus_wdata[STAT_BIT]));
endmodule

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;
  localparam int unsigned CLK_HZ = 200;
  localparam int unsigned RST_W  = 4;
  localparam int          HALF   = CLK_HZ / 2;
  localparam logic [7:0]  A_KICK = 8'h10, A_CFG = 8'h14, A_MODE = 8'h18;
  localparam logic [31:0] GOOD_KICK = {19'd0, 12'hA57, 1'b1};
  // Expected interval in half seconds for codes 0..15.
  localparam int EXP_HALVES [16] = '{1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28, 32, 32, 32, 32, 32};

  logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sys_rst_pulse, irq;
  int          cyc = 0, checks = 0, fails = 0;

  wdog_keyed #(.CLK_HZ(CLK_HZ), .RST_W(RST_W)) u_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .sys_rst_pulse(sys_rst_pulse), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Waits for an event; returns cycles since tstart, or -1 if none within limit.
  task automatic wait_fire(input int tstart, input int limit, output int delta);
    delta = -1;
    for (int i = 0; i < limit; i++) begin
      if (irq || sys_rst_pulse) begin delta = cyc - tstart; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t0, tk, dt, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_KICK, d); check("R1 kick read", d, 0);
    rd(A_CFG, d);  check("R1 cfg read", d, 0);
    rd(A_MODE, d); check("R1 mode read", d, 0);
    check("R1 sys_rst", sys_rst_pulse, 0);
    check("R1 irq", irq, 0);

    // R10 readback, R2 kick reads zero
    wr(A_CFG, 32'hFFFF_FFEE);
    rd(A_CFG, d);  check("R10 cfg readback", d, 32'h2);
    wr(A_MODE, 32'h0000_0F51);
    rd(A_MODE, d); check("R10 mode readback", d, 32'h51);
    wr(A_KICK, GOOD_KICK);
    rd(A_KICK, d); check("R2 kick reads zero", d, 0);
    wr(A_MODE, 0);

    // R3 every interval code, irq action
    for (int c = 0; c < 16; c++) begin
      wr(A_MODE, 0);
      wr(A_MODE, {24'd0, 4'(c), 4'h1});
      t0 = cyc;
      wait_fire(t0, 4000, dt);
      check($sformatf("R3 code %0d interval", c), dt, EXP_HALVES[c] * HALF);
      check("R7 irq action no reset", sys_rst_pulse, 0);
      wr(A_CFG, 32'h12);
      check("R8 irq cleared", irq, 0);
    end

    // R2 bad kicks ignored
    wr(A_MODE, 0); wr(A_MODE, 32'h11); t0 = cyc;
    idle(50);
    wr(A_KICK, {19'd0, 12'hA56, 1'b1});
    wr(A_KICK, {19'd0, 12'hA57, 1'b0});
    wait_fire(t0, 1000, dt);
    check("R2 bad key ignored", dt, 2 * HALF);
    wr(A_CFG, 32'h12);

    // R2 good kick restarts
    wr(A_MODE, 0); wr(A_MODE, 32'h11);
    idle(50);
    wr(A_KICK, GOOD_KICK); tk = cyc;
    wait_fire(tk, 1000, dt);
    check("R2 good key reload", dt, 2 * HALF);
    wr(A_CFG, 32'h12);

    // R4 re-enable keeps count; R6 new code waits for reload
    wr(A_MODE, 0); wr(A_MODE, 32'h11); t0 = cyc;
    idle(30);
    wr(A_MODE, 32'h21);
    wait_fire(t0, 1000, dt);
    check("R4 re-enable undisturbed", dt, 2 * HALF);
    wr(A_CFG, 32'h12);
    wr(A_KICK, GOOD_KICK); tk = cyc;
    wait_fire(tk, 1000, dt);
    check("R6 new code at reload", dt, 4 * HALF);
    wr(A_CFG, 32'h12);

    // R9 halted after expiry
    tk = cyc;
    wait_fire(tk, 600, dt);
    check("R9 no event after expiry", dt, -1);

    // R5 disable stops countdown
    wr(A_MODE, 0); wr(A_MODE, 32'h01);
    idle(20);
    wr(A_MODE, 0); tk = cyc;
    wait_fire(tk, 400, dt);
    check("R5 stopped", dt, -1);

    // R7 reset action: pulse width, no irq, no status
    wr(A_CFG, 32'h1);
    wr(A_MODE, 0); wr(A_MODE, 32'h01); t0 = cyc;
    wait_fire(t0, 400, dt);
    check("R7 reset interval", dt, HALF);
    check("R7 reset no irq", irq, 0);
    w = 0;
    while (sys_rst_pulse && w < 100) begin w++; @(negedge clk); end
    check("R7 pulse width", w, RST_W);
    rd(A_CFG, d); check("R7 status untouched", d, 32'h1);

    // R7 actions 00 and 11 do nothing
    wr(A_CFG, 32'h0);
    wr(A_MODE, 0); wr(A_MODE, 32'h01); t0 = cyc;
    wait_fire(t0, 300, dt);
    check("R7 action 00 silent", dt, -1);
    wr(A_CFG, 32'h3);
    wr(A_MODE, 0); wr(A_MODE, 32'h01); t0 = cyc;
    wait_fire(t0, 300, dt);
    check("R7 action 11 silent", dt, -1);

    // R8 write of 0 keeps status, write of 1 clears
    wr(A_CFG, 32'h2);
    wr(A_MODE, 0); wr(A_MODE, 32'h01); t0 = cyc;
    wait_fire(t0, 400, dt);
    wr(A_CFG, 32'h02);
    check("R8 zero write keeps irq", irq, 1);
    rd(A_CFG, d); check("R8 status readback", d, 32'h12);
    wr(A_CFG, 32'h12);
    check("R8 one write clears", irq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule